// File: doc/BRIEF.md
# Keypad Matrix Scanner

This block walks a membrane key matrix of eight drive lines and eight sense lines one key position at a time. A scan position is held as a drive index and a sense index. The drive index picks one drive line and pulls it low. The sense index is sent out to an external 8-to-1 selector, which returns a single active-low bit. That bit shows whether the key at the crossing of the two indices is pressed. A separate active-low shift input is read on its own pin.

Each step of the walk waits for a scan tick. A complete pass over all 64 positions is one full scan. The block counts the keys it finds during each full scan. A key is reported only when that same key is the only one found in two full scans in a row. The report is a 7-bit code with a one-cycle valid pulse. Three hold inputs freeze the walk while an external device is busy, while a mark is being made, or while a test function runs. The walk then resumes from the position where it stopped.

Top module: `kpd_scan_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `scan_n` is 8'hFE, `ret_sel` is 0, `key_vld` is 0 and `key_code` is 0.
- R2: In every cycle exactly one bit of `scan_n` is 0. That bit is the bit whose index equals the current drive index, and every other bit is 1.
- R3: Each accepted tick advances the position. The sense index (`ret_sel`) counts 0 to 7. When it wraps, the drive index steps up by one, and after drive index 7 it returns to 0. One full scan is 64 accepted ticks, and the position is 0 after reset.
- R4: At each accepted tick, the key at the current drive and sense indices counts as pressed when `ret_sense_n` is 0.
- R5: A key is reported when it is the only key pressed in two full scans in a row. `key_vld` goes high in the cycle after the last accepted tick of the second of those scans.
- R6: `key_code` is {shift, drive index[2:0], sense index[2:0]}. Bit 6 is the shift flag, bits 5:3 are the drive index and bits 2:0 are the sense index.
- R7: The shift flag in bit 6 is 1 when `shift_n` is 0 at the last accepted tick of the reporting scan. The shift key is not part of the matrix and never produces a report of its own.
- R8: A key that has been reported is not reported again until one of two things happens: a full scan finds no key pressed, or a different single key is found.
- R9: A full scan that finds two or more pressed keys produces no report. It also breaks the two-scan sequence that R5 needs.
- R10: While any of `hold_busy`, `hold_mark` or `hold_test` is 1, ticks are ignored. The position holds and `ret_sense_n` is not sampled. Scanning resumes from the held position once all three are 0.
- R11: `key_vld` is high for a single cycle per report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Scan step request |
| hold_busy | input | 1 | Freeze scan: external device busy |
| hold_mark | input | 1 | Freeze scan: mark in progress |
| hold_test | input | 1 | Freeze scan: test function running |
| ret_sense_n | input | 1 | Selected sense line, active low |
| shift_n | input | 1 | Shift key, active low |
| scan_n | output | 8 | Drive lines, the selected line driven low |
| ret_sel | output | 3 | Sense line select for the external selector |
| key_code | output | 7 | Reported code {shift, drive, sense} |
| key_vld | output | 1 | One-cycle report strobe |

## Verification
Some behaviours are checked by assertions on every cycle. These are the one-cold drive lines tied to the drive index, the single step of the position on each accepted tick, and the frozen position under any hold. They also cover the one-cycle width of the strobe, that a strobe only ever follows the last step of a scan, and that no strobe follows a scan with several keys. Other behaviours span several full scans, and only the bench scenarios show them. These are the two-scan debounce, suppression of repeats until release, the code values with and without shift (including the corner keys), recovery after a bounce, and that a key pressed only while paused is never sampled.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
    localparam int KP_SCAN_LINES = 8;
    localparam int KP_RET_LINES  = 8;
    localparam int KP_SCAN_W     = $clog2(KP_SCAN_LINES);
    localparam int KP_RET_W      = $clog2(KP_RET_LINES);
    localparam int KP_POS_W      = KP_SCAN_W + KP_RET_W;
    localparam int KP_CODE_W     = KP_POS_W + 1;

    typedef struct packed {
        logic                 shift;
        logic [KP_SCAN_W-1:0] scan;
        logic [KP_RET_W-1:0]  ret;
    } key_code_t;

    typedef enum logic [1:0] {
        TALLY_NONE = 2'd0,
        TALLY_ONE  = 2'd1,
        TALLY_MANY = 2'd2
    } tally_t;

    function automatic tally_t tally_add(input tally_t t, input logic hit);
        case (t)
            TALLY_NONE: return hit ? TALLY_ONE : TALLY_NONE;
            TALLY_ONE:  return hit ? TALLY_MANY : TALLY_ONE;
            default:    return TALLY_MANY;
        endcase
    endfunction
endpackage

// File: rtl/kpd_step_ctr.sv
module kpd_step_ctr
    import kpd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 hold,
    output logic [KP_SCAN_W-1:0] scan_idx,
    output logic [KP_RET_W-1:0]  ret_idx,
    output logic                 sample,
    output logic                 last_step
);
    localparam logic [KP_SCAN_W-1:0] SCAN_LAST = KP_SCAN_W'(KP_SCAN_LINES - 1);
    localparam logic [KP_RET_W-1:0]  RET_LAST  = KP_RET_W'(KP_RET_LINES - 1);

    assign sample    = tick && !hold;
    assign last_step = sample && (scan_idx == SCAN_LAST) && (ret_idx == RET_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_idx <= '0;
            ret_idx  <= '0;
        end else if (sample) begin
            if (ret_idx == RET_LAST) begin
                ret_idx  <= '0;
                scan_idx <= (scan_idx == SCAN_LAST) ? '0 : scan_idx + 1'b1;
            end else begin
                ret_idx <= ret_idx + 1'b1;
            end
        end
    end

    // R10: a hold freezes the position
    assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(scan_idx) && $stable(ret_idx)));

    // R3: sense index steps by one inside a drive line
    assert_ret_step_R3: assert property (@(posedge clk) disable iff (rst)
        (sample && ret_idx != RET_LAST) |=>
            (ret_idx == $past(ret_idx) + 1'b1 && $stable(scan_idx)));

    // R3: sense wrap moves the drive index on
    assert_scan_step_R3: assert property (@(posedge clk) disable iff (rst)
        (sample && ret_idx == RET_LAST) |=>
            (ret_idx == '0 && scan_idx != $past(scan_idx)));
endmodule

// File: rtl/kpd_line_drv.sv
module kpd_line_drv
    import kpd_pkg::*;
(
    input  logic [KP_SCAN_W-1:0]     scan_idx,
    output logic [KP_SCAN_LINES-1:0] scan_n
);
    for (genvar i = 0; i < KP_SCAN_LINES; i++) begin : g_line
        assign scan_n[i] = (scan_idx != KP_SCAN_W'(i));
    end
endmodule

// File: rtl/kpd_press_eval.sv
module kpd_press_eval
    import kpd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample,
    input  logic                 last_step,
    input  logic                 sense_n,
    input  logic                 shift_n,
    input  logic [KP_SCAN_W-1:0] scan_idx,
    input  logic [KP_RET_W-1:0]  ret_idx,
    output key_code_t            code,
    output logic                 vld
);
    tally_t                tally_q, base_tally, cur_tally;
    logic [KP_POS_W-1:0]   pos_q, cur_pos, last_pos;
    logic                  last_ok, locked, first_step, hit;

    assign first_step = (scan_idx == '0) && (ret_idx == '0);
    assign hit        = !sense_n;
    assign base_tally = first_step ? TALLY_NONE : tally_q;
    assign cur_tally  = tally_add(base_tally, hit);
    assign cur_pos    = (hit && base_tally == TALLY_NONE) ? {scan_idx, ret_idx} : pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tally_q  <= TALLY_NONE;
            pos_q    <= '0;
            last_pos <= '0;
            last_ok  <= 1'b0;
            locked   <= 1'b0;
            vld      <= 1'b0;
            code     <= '0;
        end else begin
            vld <= 1'b0;
            if (sample) begin
                tally_q <= cur_tally;
                pos_q   <= cur_pos;
            end
            if (last_step) begin
                case (cur_tally)
                    TALLY_ONE: begin
                        if (last_ok && last_pos == cur_pos && !locked) begin
                            vld    <= 1'b1;
                            code   <= '{shift: !shift_n,
                                        scan: cur_pos[KP_POS_W-1:KP_RET_W],
                                        ret:  cur_pos[KP_RET_W-1:0]};
                            locked <= 1'b1;
                        end else if (last_pos != cur_pos) begin
                            locked <= 1'b0;
                        end
                        last_ok  <= 1'b1;
                        last_pos <= cur_pos;
                    end
                    TALLY_NONE: begin
                        last_ok <= 1'b0;
                        locked  <= 1'b0;
                    end
                    default: last_ok <= 1'b0;
                endcase
            end
        end
    end

    // R11: strobe lasts one cycle
    assert_vld_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);

    // R5: a report only follows the final step of a scan
    assert_vld_after_end_R5: assert property (@(posedge clk) disable iff (rst)
        vld |-> $past(last_step));

    // R9: a crowded scan reports nothing
    assert_multi_silent_R9: assert property (@(posedge clk) disable iff (rst)
        (last_step && cur_tally == TALLY_MANY) |=> !vld);
endmodule

// File: rtl/kpd_scan_top.sv
module kpd_scan_top
    import kpd_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    input  logic                     hold_busy,
    input  logic                     hold_mark,
    input  logic                     hold_test,
    input  logic                     ret_sense_n,
    input  logic                     shift_n,
    output logic [KP_SCAN_LINES-1:0] scan_n,
    output logic [KP_RET_W-1:0]      ret_sel,
    output logic [KP_CODE_W-1:0]     key_code,
    output logic                     key_vld
);
    logic [KP_SCAN_W-1:0] scan_idx;
    logic [KP_RET_W-1:0]  ret_idx;
    logic                 sample, last_step, hold;
    key_code_t            code;

    assign hold = hold_busy || hold_mark || hold_test;

    kpd_step_ctr u_seq (
        .clk(clk), .rst(rst), .tick(tick), .hold(hold),
        .scan_idx(scan_idx), .ret_idx(ret_idx),
        .sample(sample), .last_step(last_step)
    );

    kpd_line_drv u_drv (
        .scan_idx(scan_idx), .scan_n(scan_n)
    );

    kpd_press_eval u_eval (
        .clk(clk), .rst(rst), .sample(sample), .last_step(last_step),
        .sense_n(ret_sense_n), .shift_n(shift_n),
        .scan_idx(scan_idx), .ret_idx(ret_idx),
        .code(code), .vld(key_vld)
    );

    assign ret_sel  = ret_idx;
    assign key_code = code;

    // R2: one drive line low, and it is the addressed one
    assert_line_low_R2: assert property (@(posedge clk) disable iff (rst)
        (scan_n[scan_idx] == 1'b0) && ($countones(~scan_n) == 1));
endmodule

// File: tb/sim_kpd_scan_top.sv
module sim_kpd_scan_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       hold_busy = 1'b0, hold_mark = 1'b0, hold_test = 1'b0;
    logic       ret_sense_n;
    logic       shift_n = 1'b1;
    logic [7:0] scan_n;
    logic [2:0] ret_sel;
    logic [6:0] key_code;
    logic       key_vld;

    logic [63:0] pressed = '0;
    logic [5:0]  ep = '0;
    int n_checks = 0, n_err = 0;
    bit done = 0;
    logic [6:0] expq[$];

    always #10 clk = ~clk;

    kpd_scan_top u0 (
        .clk(clk), .rst(rst), .tick(tick), .hold_busy(hold_busy),
        .hold_mark(hold_mark), .hold_test(hold_test),
        .ret_sense_n(ret_sense_n), .shift_n(shift_n),
        .scan_n(scan_n), .ret_sel(ret_sel), .key_code(key_code), .key_vld(key_vld)
    );

    // matrix model: selected drive line low, selected sense bit active low
    always_comb begin
        ret_sense_n = 1'b1;
        for (int i = 0; i < 8; i++)
            if (!scan_n[i] && pressed[i*8 + int'(ret_sel)]) ret_sense_n = 1'b0;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pop expected codes as reports appear
    always @(negedge clk) begin
        if (!rst && key_vld) begin
            if (expq.size() == 0) chk("R5 unexpected report", int'(key_code), 'h80);
            else chk("R6 code", int'(key_code), int'(expq.pop_front()));
        end
    end

    task automatic run_ticks(input int n);
        bit bad = 0;
        for (int s = 0; s < n; s++) begin
            @(negedge clk);
            if (scan_n !== ~(8'b1 << ep[5:3]) || ret_sel !== ep[2:0]) bad = 1;
            tick = 1'b1;
            @(posedge clk);
            ep = ep + 6'd1;
        end
        @(negedge clk);
        tick = 1'b0;
        chk("R2 R3 walk", int'(bad), 0);
    endtask

    task automatic scans(input int n);
        run_ticks(64 * n);
    endtask

    task automatic drained(input string tag);
        @(negedge clk);
        chk(tag, expq.size(), 0);
    endtask

    function automatic int kidx(input int s, input int r);
        return s * 8 + r;
    endfunction

    task automatic pause_with(input int which);
        logic [7:0] s0;
        logic [2:0] r0;
        @(negedge clk);
        hold_busy = (which == 0);
        hold_mark = (which == 1);
        hold_test = (which == 2);
        tick = 1'b1;
        s0 = scan_n;
        r0 = ret_sel;
        repeat (4) begin
            @(negedge clk);
            chk("R10 hold position", {21'd0, scan_n, ret_sel}, {21'd0, s0, r0});
        end
        hold_busy = 1'b0; hold_mark = 1'b0; hold_test = 1'b0;
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 scan_n", int'(scan_n), 'hFE);
        chk("R1 ret_sel", int'(ret_sel), 0);
        chk("R1 key_vld", int'(key_vld), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {int'(key_vld), int'(key_code)}, 0);

        // R4 R5 R6: single key, two scans
        pressed[kidx(2,5)] = 1'b1;
        scans(1);
        drained("R5 no report after one scan");
        expq.push_back(7'h15);
        scans(1);
        drained("R5 report after two scans");

        // R8: held key, no repeat
        scans(2);
        drained("R8 held key silent");
        pressed = '0;
        scans(1);
        pressed[kidx(2,5)] = 1'b1;
        expq.push_back(7'h15);
        scans(2);
        drained("R8 report after release");

        // R7: shift and corner keys
        pressed = '0;
        scans(1);
        shift_n = 1'b0;
        pressed[kidx(7,0)] = 1'b1;
        expq.push_back(7'h78);
        scans(2);
        drained("R7 shifted code");

        // R9: second key joins, then two new keys together
        pressed[kidx(1,1)] = 1'b1;
        scans(2);
        drained("R9 two keys silent");
        pressed = '0;
        shift_n = 1'b1;
        pressed[kidx(1,1)] = 1'b1;
        pressed[kidx(6,6)] = 1'b1;
        scans(2);
        drained("R9 fresh pair silent");

        // R8: different single key after multi clears lock
        pressed = '0;
        pressed[kidx(0,0)] = 1'b1;
        expq.push_back(7'h00);
        scans(2);
        drained("R8 new key reported");

        // R5: bounce restarts debounce
        pressed = '0;
        scans(1);
        pressed[kidx(7,7)] = 1'b1;
        scans(1);
        pressed = '0;
        scans(1);
        pressed[kidx(7,7)] = 1'b1;
        shift_n = 1'b0;
        scans(1);
        drained("R5 bounce silent");
        expq.push_back(7'h7F);
        scans(1);
        drained("R5 R6 corner code with shift");

        // R10: pauses; key pressed only during pause is not sampled
        pressed = '0;
        shift_n = 1'b1;
        scans(1);
        pressed[kidx(3,3)] = 1'b1;
        scans(1);
        expq.push_back(7'h1B);
        run_ticks(20);
        pressed[kidx(2,4)] = 1'b1;
        pause_with(0);
        pause_with(1);
        pause_with(2);
        pressed[kidx(2,4)] = 1'b0;
        run_ticks(44);
        drained("R10 resume and report");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule